// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers bytes from an asynchronous serial line whose idle level is high. The line is sampled on a sample-clock enable (`tick_en`) that runs at a fixed multiple of the bit rate, eight ticks per bit by default. Ticks within a bit are numbered from 0. The line first passes through a two-flop synchronizer.

Bit timing starts only at the falling edge that begins a start bit. The start bit is checked again at its centre. Each data bit is the majority of three samples taken around its centre. The stop bit is read at its centre.

A good frame gives a one-cycle `rx_valid` pulse with the byte on `rx_data`. If the stop bit is low, the block reports a break when every data bit was low, and a framing error otherwise. After either error it waits for the line to return high before it looks for another start bit.

Top module: `serial_rx_os`

## Requirements
- R1: While `rst` is high and in the cycle after it, `rx_valid`, `frame_err` and `break_det` are 0 and `rx_data` is 0x00.
- R2: A start is recognised only at a tick that sees the synchronized line low after a tick that saw it high. A line that has been low since reset never starts a frame.
- R3: The start bit is sampled again at tick 4 counted from the edge tick (tick 0). If the line is high there, the frame is dropped with no output pulse.
- R4: A frame is one start bit, then 8 data bits least-significant bit first, then one stop bit. Each data bit is the majority of its samples at ticks 3, 4 and 5, so values at other ticks of the bit have no effect.
- R5: A high stop bit at its tick 4 gives a one-cycle `rx_valid` pulse with `rx_data` equal to the received byte.
- R6: A low stop bit with a nonzero byte gives a one-cycle `frame_err` pulse, and `rx_data` keeps its previous value.
- R7: A low stop bit with an all-zero byte gives a one-cycle `break_det` pulse instead of `frame_err`.
- R8: After R6 or R7, no frame starts while the line stays low. The receiver accepts a new frame only once a tick has seen the line high.
- R9: At most one of the three output pulses is high in any cycle. Each pulse follows a cycle in which `tick_en` was high, and `rx_data` changes only together with `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Sample enable, TICKS_PER_BIT pulses per bit |
| rx_line | input | 1 | Serial input line, idle high |
| rx_data | output | DATA_BITS | Last byte received in a good frame |
| rx_valid | output | 1 | One-cycle pulse for a good frame |
| frame_err | output | 1 | One-cycle pulse for a low stop bit with nonzero data |
| break_det | output | 1 | One-cycle pulse for a low stop bit with all-zero data |

## Verification
The assertions assume that `tick_en` is a clean enable and that reset is held for at least one clock before use. They assume nothing about the line, so their checks on pulse exclusivity and data stability hold for any waveform. The stimulus drives the line in whole tick slots, each two clocks long, with `tick_en` high in the first clock of each slot. This keeps a fixed, known offset between each stimulus slot and the tick index the receiver counts, so glitches can be aimed at exact tick positions inside and outside the voting window.

// File: rtl/serial_rx_os_pkg.sv
package serial_rx_os_pkg;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_STOP  = 3'd3,
        RX_HOLD  = 3'd4
    } rx_state_e;

    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/serial_rx_os_sync.sv
module serial_rx_os_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    // Reset to low: no falling edge can be inferred until a high is seen.
    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/serial_rx_os_vote.sv
module serial_rx_os_vote (
    input  logic clk,
    input  logic rst,
    input  logic cap_first,
    input  logic cap_second,
    input  logic din,
    output logic vote
);
    import serial_rx_os_pkg::*;

    typedef struct packed {
        logic s0;
        logic s1;
    } vote_t;

    vote_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (cap_first)  r_d.s0 = din;
        if (cap_second) r_d.s1 = din;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    // Third sample is the live line value on the closing tick.
    assign vote = majority3(r_q.s0, r_q.s1, din);
endmodule

// File: rtl/serial_rx_os.sv
module serial_rx_os #(
    parameter int TICKS_PER_BIT = 8,
    parameter int DATA_BITS     = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic                 rx_line,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 frame_err,
    output logic                 break_det
);
    import serial_rx_os_pkg::*;

    localparam int CW = $clog2(TICKS_PER_BIT);
    localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CW-1:0] T_LAST = CW'(TICKS_PER_BIT - 1);
    localparam logic [CW-1:0] T_MID  = CW'(TICKS_PER_BIT / 2);
    localparam logic [CW-1:0] T_VA   = CW'(TICKS_PER_BIT / 2 - 1);
    localparam logic [CW-1:0] T_VC   = CW'(TICKS_PER_BIT / 2 + 1);
    localparam logic [BW-1:0] B_LAST = BW'(DATA_BITS - 1);

    typedef struct packed {
        rx_state_e            state;
        logic [CW-1:0]        cnt;
        logic [BW-1:0]        bitn;
        logic                 last_hi;
        logic [DATA_BITS-1:0] shreg;
        logic [DATA_BITS-1:0] data;
        logic                 valid;
        logic                 ferr;
        logic                 brk;
    } rx_regs_t;

    rx_regs_t r_q, r_d;

    logic          line_s;
    logic          vote;
    logic          cap_a, cap_b;
    logic [CW-1:0] idx;

    serial_rx_os_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (line_s)
    );

    serial_rx_os_vote u_vote (
        .clk        (clk),
        .rst        (rst),
        .cap_first  (cap_a),
        .cap_second (cap_b),
        .din        (line_s),
        .vote       (vote)
    );

    // Tick index this tick belongs to, relative to the start edge (tick 0).
    always_comb idx = (r_q.cnt == T_LAST) ? '0 : r_q.cnt + 1'b1;

    assign cap_a = tick_en && (r_q.state == RX_DATA) && (idx == T_VA);
    assign cap_b = tick_en && (r_q.state == RX_DATA) && (idx == T_MID);

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.ferr  = 1'b0;
        r_d.brk   = 1'b0;
        if (tick_en) begin
            unique case (r_q.state)
                RX_IDLE: begin
                    r_d.last_hi = line_s;
                    if (!line_s && r_q.last_hi) begin
                        r_d.state = RX_START;
                        r_d.cnt   = '0;
                    end
                end
                RX_START: begin
                    r_d.cnt = idx;
                    if (idx == T_MID && line_s) begin
                        r_d.state   = RX_IDLE;
                        r_d.last_hi = 1'b1;
                    end else if (idx == T_LAST) begin
                        r_d.state = RX_DATA;
                        r_d.bitn  = '0;
                    end
                end
                RX_DATA: begin
                    r_d.cnt = idx;
                    if (idx == T_VC) begin
                        r_d.shreg = {vote, r_q.shreg[DATA_BITS-1:1]};
                    end
                    if (idx == T_LAST) begin
                        if (r_q.bitn == B_LAST) r_d.state = RX_STOP;
                        else                    r_d.bitn  = r_q.bitn + 1'b1;
                    end
                end
                RX_STOP: begin
                    r_d.cnt = idx;
                    if (idx == T_MID) begin
                        if (line_s) begin
                            r_d.valid   = 1'b1;
                            r_d.data    = r_q.shreg;
                            r_d.state   = RX_IDLE;
                            r_d.last_hi = 1'b1;
                        end else begin
                            if (r_q.shreg == '0) r_d.brk  = 1'b1;
                            else                 r_d.ferr = 1'b1;
                            r_d.state = RX_HOLD;
                        end
                    end
                end
                RX_HOLD: begin
                    if (line_s) begin
                        r_d.state   = RX_IDLE;
                        r_d.last_hi = 1'b1;
                    end
                end
                default: r_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.state <= RX_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_data   = r_q.data;
    assign rx_valid  = r_q.valid;
    assign frame_err = r_q.ferr;
    assign break_det = r_q.brk;
endmodule

// File: rtl/serial_rx_os_chk.sv
module serial_rx_os_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick_en,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_valid,
    input logic                 frame_err,
    input logic                 break_det
);
    logic primed_q;

    always_ff @(posedge clk) begin
        if (rst) primed_q <= 1'b1;
    end

    // R1: outputs cleared in the cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        (primed_q === 1'b1 && $past(rst)) |-> (!rx_valid && !frame_err && !break_det && rx_data == '0));

    // R9: pulses exclusive
    p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        (primed_q === 1'b1) |-> $onehot0({rx_valid, frame_err, break_det}));

    // R5: valid is a single-cycle pulse
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (primed_q === 1'b1 && rx_valid) |=> !rx_valid);

    // R6 / R7: error pulses last one cycle
    p_err_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (primed_q === 1'b1 && (frame_err || break_det)) |=> (!frame_err && !break_det));

    // R9: every pulse follows a tick
    p_after_tick_r9: assert property (@(posedge clk) disable iff (rst)
        (primed_q === 1'b1 && !$past(rst) && (rx_valid || frame_err || break_det)) |-> $past(tick_en));

    // R6 / R9: data changes only with a valid pulse
    p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (primed_q === 1'b1 && !$past(rst) && !rx_valid) |-> $stable(rx_data));
endmodule

bind serial_rx_os serial_rx_os_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .frame_err (frame_err),
    .break_det (break_det)
);

// File: tb/serial_rx_os_test.sv
module serial_rx_os_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       rx_line = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, frame_err, break_det;

    int tests = 0;
    int fails = 0;
    int n_valid = 0, n_ferr = 0, n_brk = 0;
    logic [7:0] last_data = 8'h00;
    bit done = 0;

    always #5 clk = ~clk;

    serial_rx_os uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rx_line(rx_line),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .frame_err(frame_err), .break_det(break_det)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin n_valid++; last_data = rx_data; end
            if (frame_err) n_ferr++;
            if (break_det) n_brk++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_valid = 0; n_ferr = 0; n_brk = 0;
    endtask

    // One tick slot: two clocks, tick in the first.
    task automatic slot(input logic v);
        @(negedge clk);
        rx_line = v;
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic slots(input logic v, input int n);
        for (int i = 0; i < n; i++) slot(v);
    endtask

    // Frame with optional glitch mask on one data bit.
    task automatic send(input logic [7:0] d, input logic stop, input int gbit, input logic [7:0] gmask);
        slots(1'b0, 8);
        for (int b = 0; b < 8; b++) begin
            for (int s = 0; s < 8; s++) begin
                slot((b == gbit && gmask[s]) ? ~d[b] : d[b]);
            end
        end
        slots(stop, 8);
    endtask

    task automatic expect_good(input logic [7:0] d, input string req);
        check(n_valid == 1 && n_ferr == 0 && n_brk == 0, req, n_valid, 1);
        check(last_data == d && rx_data == d, req, last_data, d);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (5) @(negedge clk);
        check(rx_valid == 0, "R1 valid", rx_valid, 0);
        check(frame_err == 0, "R1 ferr", frame_err, 0);
        check(break_det == 0, "R1 brk", break_det, 0);
        check(rx_data == 0, "R1 data", rx_data, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!rx_valid && !frame_err && !break_det && rx_data == 0, "R1 after", rx_data, 0);

        // R2: line low since reset never starts a frame
        clear_counts();
        slots(1'b0, 120);
        check(n_valid + n_ferr + n_brk == 0, "R2 low from reset", n_valid + n_ferr + n_brk, 0);
        slots(1'b1, 12);
        clear_counts();
        send(8'hC3, 1'b1, -1, 8'h00);
        slots(1'b1, 4);
        expect_good(8'hC3, "R2 first frame");

        // R4 R5: sweep all byte values
        for (int v = 0; v < 256; v++) begin
            clear_counts();
            send(8'(v), 1'b1, -1, 8'h00);
            slots(1'b1, 4);
            expect_good(8'(v), "R5 sweep");
        end

        // R4: glitches on each bit of several bytes
        for (int k = 0; k < 3; k++) begin
            logic [7:0] d;
            d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'hA5;
            for (int b = 0; b < 8; b++) begin
                // single glitch at centre tick: rejected by vote
                clear_counts();
                send(d, 1'b1, b, 8'b0001_0000);
                slots(1'b1, 4);
                expect_good(d, "R4 single glitch");
                // glitches outside the window: ignored
                clear_counts();
                send(d, 1'b1, b, 8'b1100_0111);
                slots(1'b1, 4);
                expect_good(d, "R4 outside window");
                // two of three window samples flipped
                clear_counts();
                send(d, 1'b1, b, 8'b0001_1000);
                slots(1'b1, 4);
                expect_good(d ^ (8'h01 << b), "R4 flip 3,4");
                clear_counts();
                send(d, 1'b1, b, 8'b0011_0000);
                slots(1'b1, 4);
                expect_good(d ^ (8'h01 << b), "R4 flip 4,5");
            end
        end

        // R3: start bit shorter than half a bit is dropped
        clear_counts();
        slots(1'b0, 4);
        slots(1'b1, 100);
        check(n_valid + n_ferr + n_brk == 0, "R3 false start", n_valid + n_ferr + n_brk, 0);
        clear_counts();
        send(8'h3C, 1'b1, -1, 8'h00);
        slots(1'b1, 4);
        expect_good(8'h3C, "R3 recovery");

        // R6: framing error keeps data
        clear_counts();
        send(8'h5A, 1'b0, -1, 8'h00);
        slots(1'b0, 4);
        check(n_ferr == 1 && n_brk == 0 && n_valid == 0, "R6 ferr", n_ferr, 1);
        check(rx_data == 8'h3C, "R6 data kept", rx_data, 8'h3C);
        // R8: stays held while line low
        clear_counts();
        slots(1'b0, 100);
        check(n_valid + n_ferr + n_brk == 0, "R8 hold after ferr", n_valid + n_ferr + n_brk, 0);
        slots(1'b1, 3);
        clear_counts();
        send(8'h81, 1'b1, -1, 8'h00);
        slots(1'b1, 4);
        expect_good(8'h81, "R8 resume after ferr");

        // R7: break on all-zero data with low stop
        clear_counts();
        send(8'h00, 1'b0, -1, 8'h00);
        slots(1'b0, 4);
        check(n_brk == 1 && n_ferr == 0 && n_valid == 0, "R7 break", n_brk, 1);
        check(rx_data == 8'h81, "R7 data kept", rx_data, 8'h81);
        clear_counts();
        slots(1'b0, 150);
        check(n_valid + n_ferr + n_brk == 0, "R8 hold after break", n_valid + n_ferr + n_brk, 0);
        slots(1'b1, 1);
        clear_counts();
        send(8'h7E, 1'b1, -1, 8'h00);
        slots(1'b1, 4);
        expect_good(8'h7E, "R8 resume after break");

        // R9: back-to-back frames with minimal idle
        clear_counts();
        send(8'h12, 1'b1, -1, 8'h00);
        send(8'h34, 1'b1, -1, 8'h00);
        slots(1'b1, 4);
        check(n_valid == 2 && n_ferr == 0 && n_brk == 0, "R9 back-to-back", n_valid, 2);
        check(last_data == 8'h34, "R9 last data", last_data, 8'h34);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule